// File: doc/BRIEF.md
# NRZI Decoder with Self-Synchronizing Descrambler

This block sits right after clock recovery in a serial video receive path. It takes one recovered bit per clock, qualified by a strobe, and returns the original payload bit stream. The transmitter divided the data by the generator (x^9 + x^4 + 1)(x + 1). The (x + 1) factor shows up on the line as NRZI coding. The receiver undoes this by multiplying by the same generator, modulo 2, in two feed-forward steps.

The first step turns NRZI into NRZ by marking every change of level. The second step cancels the x^9 + x^4 + 1 scrambling. Both steps look only at a short window of past line bits and have no feedback, so there is no seed to load. Any start-up state, and any encoder state, is flushed out of the window after a fixed run of bits. The restored stream goes on to word alignment, which is outside this block.

Top module: `nrzi_descrambler`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `dat_valid` is low.
- R2: The NRZ value of each line bit is 1 when it differs from the previous accepted line bit and 0 when it equals it. A constant line level therefore restores to all zeros, and a level that toggles on every bit restores to all ones.
- R3: Let y[n] be the NRZ value of accepted bit n. The restored bit for accepted bit n is y[n] XOR y[n-4] XOR y[n-9]. A single level change at accepted index k gives ones at exactly k, k+4 and k+9.
- R4: The first 10 accepted bits after reset produce no valid output, with indices counted from 0. Every accepted bit from index 10 onward produces exactly one valid output.
- R5: A cycle with `ser_valid` low changes no history and produces `dat_valid` low one cycle later. The restored sequence is the same with or without such idle cycles.
- R6: With the default registered output, `dat_bit` and `dat_valid` for a line bit accepted at one rising edge appear after that edge and hold until the next edge.
- R7: Data divided by the generator and then NRZI coded, starting from any encoder state, is restored bit for bit from accepted index 10 onward.
- R8: A synchronous reset in mid-stream restarts the 10-bit fill. After the fill, output matches again without the encoder being reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered bit clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_bit | input | 1 | Line bit, NRZI coded and scrambled |
| ser_valid | input | 1 | Qualifies `ser_bit` in this cycle |
| dat_bit | output | 1 | Restored payload bit |
| dat_valid | output | 1 | Qualifies `dat_bit` |

## Verification
The bench targets the edges of the fill window: index 9 must still be silent and index 10 must already be valid. An off-by-one counter would either leak a garbage bit or drop the first good one. An impulse test places a single line transition after warm-up and expects ones at exactly three offsets. Wrong tap positions, or a descrambler fed the raw line instead of the NRZ value, would move or add ones. Constant and toggling line levels expose an inverted or missing NRZI stage. A random stream with idle gaps, and a stream resumed after a mid-stream reset with the encoder left running, catch history that advances on idle cycles and fill logic that does not restart.

// File: rtl/nrzi_dscr_pkg.sv
package nrzi_dscr_pkg;
   // Default feed-forward taps of the x^9 + x^4 + 1 section.
   localparam int unsigned DEF_TAP_NEAR = 4;
   localparam int unsigned DEF_TAP_FAR  = 9;

   // Accepted bits needed before the output no longer depends on start-up state:
   // the far tap of the descrambler plus one bit of NRZI history.
   function automatic int unsigned fill_bits(input int unsigned tap_far);
      return tap_far + 1;
   endfunction

   function automatic int unsigned cnt_width(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction
endpackage

// File: rtl/nrzi_edge_decode.sv
module nrzi_edge_decode (
   input  logic clk,
   input  logic rst,
   input  logic step,
   input  logic line_bit,
   output logic nrz_bit
);
   logic last_q;

   always_ff @(posedge clk) begin
      if (rst)       last_q <= 1'b0;
      else if (step) last_q <= line_bit;
   end

   assign nrz_bit = line_bit ^ last_q;
endmodule

// File: rtl/ff_descramble.sv
module ff_descramble #(
   parameter int unsigned TAP_NEAR = 4,
   parameter int unsigned TAP_FAR  = 9
) (
   input  logic clk,
   input  logic rst,
   input  logic step,
   input  logic nrz_bit,
   output logic plain_bit
);
   logic [TAP_FAR:1] hist_q;

   generate
      if (TAP_FAR > 1) begin : g_wide
         always_ff @(posedge clk) begin
            if (rst)       hist_q <= '0;
            else if (step) hist_q <= {hist_q[TAP_FAR-1:1], nrz_bit};
         end
      end else begin : g_single
         always_ff @(posedge clk) begin
            if (rst)       hist_q <= '0;
            else if (step) hist_q <= nrz_bit;
         end
      end
   endgenerate

   assign plain_bit = nrz_bit ^ hist_q[TAP_NEAR] ^ hist_q[TAP_FAR];
endmodule

// File: rtl/fill_gate.sv
module fill_gate #(
   parameter int unsigned FILL = 10
) (
   input  logic clk,
   input  logic rst,
   input  logic step,
   output logic primed
);
   localparam int unsigned CW = nrzi_dscr_pkg::cnt_width(FILL);
   localparam logic [CW-1:0] LIMIT = CW'(FILL);

   logic [CW-1:0] seen_q;

   always_ff @(posedge clk) begin
      if (rst)                         seen_q <= '0;
      else if (step && seen_q != LIMIT) seen_q <= seen_q + 1'b1;
   end

   assign primed = (seen_q == LIMIT);
endmodule

// File: rtl/nrzi_descrambler.sv
module nrzi_descrambler #(
   parameter int unsigned TAP_NEAR = nrzi_dscr_pkg::DEF_TAP_NEAR,
   parameter int unsigned TAP_FAR  = nrzi_dscr_pkg::DEF_TAP_FAR,
   parameter bit          OUT_REG  = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic ser_bit,
   input  logic ser_valid,
   output logic dat_bit,
   output logic dat_valid
);
   localparam int unsigned FILL = nrzi_dscr_pkg::fill_bits(TAP_FAR);

   generate
      if (TAP_NEAR < 1 || TAP_NEAR >= TAP_FAR)
         $error("nrzi_descrambler: TAP_NEAR must lie in 1..TAP_FAR-1");
   endgenerate

   logic nrz_w, plain_w, primed_w;

   nrzi_edge_decode u_edge (
      .clk(clk), .rst(rst), .step(ser_valid),
      .line_bit(ser_bit), .nrz_bit(nrz_w)
   );

   ff_descramble #(.TAP_NEAR(TAP_NEAR), .TAP_FAR(TAP_FAR)) u_dscr (
      .clk(clk), .rst(rst), .step(ser_valid),
      .nrz_bit(nrz_w), .plain_bit(plain_w)
   );

   fill_gate #(.FILL(FILL)) u_fill (
      .clk(clk), .rst(rst), .step(ser_valid), .primed(primed_w)
   );

   generate
      if (OUT_REG) begin : g_reg_out
         logic bit_q, vld_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               bit_q <= 1'b0;
               vld_q <= 1'b0;
            end else begin
               bit_q <= plain_w & ser_valid & primed_w;
               vld_q <= ser_valid & primed_w;
            end
         end
         assign dat_bit   = bit_q;
         assign dat_valid = vld_q;
      end else begin : g_comb_out
         assign dat_valid = ser_valid & primed_w & ~rst;
         assign dat_bit   = plain_w & dat_valid;
      end
   endgenerate
endmodule

// File: rtl/nrzi_descrambler_chk.sv
module nrzi_descrambler_chk #(
   parameter int unsigned TAP_NEAR = 4,
   parameter int unsigned TAP_FAR  = 9,
   parameter bit          OUT_REG  = 1'b1
) (
   input logic clk,
   input logic rst,
   input logic ser_bit,
   input logic ser_valid,
   input logic dat_bit,
   input logic dat_valid
);
   localparam int unsigned FILL = TAP_FAR + 1;

   // Raw line history: line_q[k] is the line bit accepted k steps ago.
   logic [TAP_FAR+1:1] line_q;
   int unsigned        seen_q;
   logic               exp_c;

   always_ff @(posedge clk) begin
      if (rst) begin
         line_q <= '0;
         seen_q <= 0;
      end else if (ser_valid) begin
         line_q <= {line_q[TAP_FAR:1], ser_bit};
         if (seen_q < FILL) seen_q <= seen_q + 1;
      end
   end

   // Product with (x+1)(x^9+x^4+1) on raw line bits.
   assign exp_c = ser_bit ^ line_q[1] ^ line_q[TAP_NEAR] ^ line_q[TAP_NEAR+1]
                ^ line_q[TAP_FAR] ^ line_q[TAP_FAR+1];

   generate
      if (OUT_REG) begin : g_reg
         a_r4_no_early_valid: assert property (@(posedge clk) disable iff (rst)
            dat_valid |-> $past(ser_valid && seen_q == FILL));
         a_r4_valid_after_fill: assert property (@(posedge clk) disable iff (rst)
            (ser_valid && seen_q == FILL) |=> dat_valid);
         a_r5_idle_silent: assert property (@(posedge clk) disable iff (rst)
            !ser_valid |=> !dat_valid);
         a_r3_product: assert property (@(posedge clk) disable iff (rst)
            dat_valid |-> dat_bit == $past(exp_c));
      end else begin : g_comb
         a_r4_no_early_valid: assert property (@(posedge clk) disable iff (rst)
            dat_valid |-> (ser_valid && seen_q == FILL));
         a_r4_valid_after_fill: assert property (@(posedge clk) disable iff (rst)
            (ser_valid && seen_q == FILL) |-> dat_valid);
         a_r5_idle_silent: assert property (@(posedge clk) disable iff (rst)
            !ser_valid |-> !dat_valid);
         a_r3_product: assert property (@(posedge clk) disable iff (rst)
            dat_valid |-> dat_bit == exp_c);
      end
   endgenerate
endmodule

bind nrzi_descrambler nrzi_descrambler_chk #(
   .TAP_NEAR(TAP_NEAR), .TAP_FAR(TAP_FAR), .OUT_REG(OUT_REG)
) u_chk (
   .clk(clk), .rst(rst), .ser_bit(ser_bit), .ser_valid(ser_valid),
   .dat_bit(dat_bit), .dat_valid(dat_valid)
);

// File: tb/nrzi_descrambler_bench.sv
module nrzi_descrambler_bench;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ser_bit = 1'b0;
   logic ser_valid = 1'b0;
   logic dat_bit, dat_valid;

   int n_checks = 0;
   int n_fail   = 0;
   int n_in     = 0;
   bit finished = 1'b0;

   // Bench-side encoder: divide by x^9+x^4+1, then NRZI.
   logic [9:1] enc_s = 9'h0;
   logic       enc_line = 1'b0;

   always #4 clk = ~clk;

   nrzi_descrambler u_nrzi_descrambler (
      .clk(clk), .rst(rst), .ser_bit(ser_bit), .ser_valid(ser_valid),
      .dat_bit(dat_bit), .dat_valid(dat_valid)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b (accepted index %0d)", req, act, exp, n_in);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; ser_valid = 1'b0; ser_bit = 1'b0;
      @(negedge clk);
      check("R1", dat_valid, 1'b0);
      @(negedge clk);
      rst = 1'b0;
      @(posedge clk); #1;
      check("R1", dat_valid, 1'b0);
      n_in = 0;
   endtask

   // Drive one line cycle; exp_b is the expected restored bit if output is due.
   task automatic push_raw(input logic b, input logic v, input logic exp_b, input string req);
      logic due;
      due = v && (n_in >= 10);
      @(negedge clk);
      ser_bit = b; ser_valid = v;
      @(posedge clk); #1;
      check(v ? "R4" : "R5", dat_valid, due);
      if (due) check(req, dat_bit, exp_b);
      if (v) n_in++;
   endtask

   task automatic push_data(input logic d, input logic v, input string req);
      logic s;
      if (v) begin
         s = d ^ enc_s[4] ^ enc_s[9];
         enc_s = {enc_s[8:1], s};
         enc_line = enc_line ^ s;
      end
      push_raw(enc_line, v, d, req);
   endtask

   task automatic t_constant_line();
      do_reset();
      for (int i = 0; i < 30; i++) push_raw(1'b1, 1'b1, 1'b0, "R2");
   endtask

   task automatic t_toggle_line();
      do_reset();
      for (int i = 0; i < 30; i++) push_raw(i[0], 1'b1, 1'b1, "R2");
   endtask

   task automatic t_impulse();
      do_reset();
      for (int i = 0; i < 40; i++)
         push_raw(i >= 15, 1'b1, (i == 15) || (i == 19) || (i == 24), "R3");
   endtask

   task automatic t_fill_edge();
      do_reset();
      // Indices 0..9 must stay silent, index 10 must be valid (push_raw checks R4).
      for (int i = 0; i < 12; i++) push_data(1'(i % 3 == 0), 1'b1, "R4");
   endtask

   task automatic t_random_roundtrip();
      enc_s = 9'h1A5; enc_line = 1'b1;
      do_reset();
      for (int i = 0; i < 400; i++) push_data(1'($urandom_range(1, 0)), 1'b1, "R7");
   endtask

   task automatic t_idle_gaps();
      do_reset();
      for (int i = 0; i < 300; i++)
         push_data(1'($urandom_range(1, 0)), ($urandom_range(9, 0) < 7), "R5");
   endtask

   task automatic t_midstream_reset();
      for (int i = 0; i < 50; i++) push_data(1'($urandom_range(1, 0)), 1'b1, "R8");
      enc_s = 9'h0C3;
      do_reset();
      for (int i = 0; i < 60; i++) push_data(1'($urandom_range(1, 0)), 1'b1, "R8");
   endtask

   task automatic t_output_hold();
      // R6: result present after the capturing edge persists until the next edge.
      logic held;
      push_data(1'b1, 1'b1, "R6");
      held = dat_bit;
      @(negedge clk);
      check("R6", dat_bit, held);
      check("R6", dat_valid, 1'b1);
   endtask

   initial begin
      t_constant_line();
      t_toggle_line();
      t_impulse();
      t_fill_edge();
      t_random_roundtrip();
      t_output_hold();
      t_idle_gaps();
      t_midstream_reset();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < 150000; c++) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end
endmodule